// File: doc/BRIEF.md
# Last-Gasp Flush Sequencer

This block watches a digitised supply reading and, when the supply sags below a programmed level for long enough, takes the chip through an autonomous power-down commit. It raises a sticky power-fail flag with a one-cycle interrupt, switches off non-critical loads, freezes the energy and charge accumulators, and writes a fixed page of words to non-volatile storage through a single-word write port with a busy/done handshake. The page holds the frozen accumulator values, the most recent high-severity events newest first, a power-down record carrying a cause code and a time marker, and finally a seal word. A page without its seal is incomplete by definition.

The same sequence can also be started by a protection trip or a host shutdown request, and the cause code tells the three apart. Two counters bound the run: a per-word timeout and an overall cycle budget. Either one ending the run puts the block in an abort state without ever issuing the seal. Once started, the sequence needs nothing from the host and ignores any later change on the supply or the trigger inputs.

Top module: `lgasp_seq`

## Requirements
- R1: The power-fail flag rises at the clock edge that takes the valid sample completing a run of max(fail_debounce,1) consecutive valid samples with supply_level strictly below fail_threshold (unsigned). A valid sample at or above the threshold restarts the run, and cycles without sample_valid neither count nor restart it. The flag stays high until reset, and pfail_irq is high for exactly the one cycle in which the flag first reads high.
- R2: When idle, the sequence starts at the edge where a brown-out run completes, prot_trip is high, or host_off is high. loads_off goes high at that edge and stays high until reset. The 8-bit cause code is 1 for brown-out, 2 for host shutdown and 3 for protection trip. When several triggers coincide, protection trip wins over brown-out, and brown-out wins over host shutdown.
- R3: Before the start, each valid sample adds energy_inc to energy_acc and charge_inc to charge_acc, both 32 bits and wrapping. The sample taken at the start edge and every later sample add nothing.
- R4: Only events with evt_high_sev=1 are kept, and only the EVT_DEPTH most recent of them. Events arriving at or after the start edge are not kept.
- R5: The page is written at ascending addresses from 0: energy, charge, then the n kept events newest first (n = min(kept, EVT_DEPTH)), then the power-down record, then the seal {24'h5EA1ED, 8-bit total word count n+4}.
- R6: A write is a one-cycle nvm_wr_en pulse issued only while nvm_busy is low. The next write waits for nvm_done, and each page address is written exactly once.
- R7: The power-down record is {cause[7:0], tick[23:0]}. tick is a counter cleared by reset and advanced every clock, taken as it stood just before the start edge.
- R8: If a word has not completed within write_timeout cycles of its first cycle pending, the sequence aborts. No later word and no seal is written.
- R9: If the page is not complete when cycle_budget cycles have elapsed since the start, the sequence aborts and the seal is not written.
- R10: Once started, the run ignores supply recovery and new triggers. flush_done rises after the seal write's nvm_done. flush_done and flush_abort are never high together and each stays high until reset.
- R11: During and just after reset all outputs are low, including both accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Supply and metering sample strobe |
| supply_level | input | LVL_W | Digitised supply reading |
| fail_threshold | input | LVL_W | Brown-out level |
| fail_debounce | input | DEB_W | Consecutive low samples required (0 acts as 1) |
| energy_inc | input | INC_W | Energy increment per sample |
| charge_inc | input | INC_W | Charge increment per sample |
| evt_valid | input | 1 | Event strobe |
| evt_high_sev | input | 1 | Event is high severity |
| evt_data | input | 32 | Event record word |
| prot_trip | input | 1 | Protection trip request |
| host_off | input | 1 | Host shutdown request |
| cycle_budget | input | BUD_W | Cycles allowed for the whole page |
| write_timeout | input | TMO_W | Cycles allowed per word |
| nvm_busy | input | 1 | Storage port busy |
| nvm_done | input | 1 | Storage word write complete |
| pfail_flag | output | 1 | Sticky power-fail flag |
| pfail_irq | output | 1 | Power-fail interrupt pulse |
| loads_off | output | 1 | Non-critical load gate |
| energy_acc | output | 32 | Energy accumulator |
| charge_acc | output | 32 | Charge accumulator |
| nvm_wr_en | output | 1 | Word write request |
| nvm_addr | output | AW | Word address |
| nvm_wdata | output | 32 | Word data |
| flush_done | output | 1 | Page complete and sealed |
| flush_abort | output | 1 | Run ended without a seal |

## Verification
The assertions assume that write_timeout and cycle_budget are nonzero and stay fixed while a run is in progress. They also assume that the storage port answers one request with a single nvm_done pulse and never pulses nvm_done while no request is outstanding. The bench writes both limits only during reset and leaves them unchanged until the next reset. Its storage model raises busy after it takes a request and returns exactly one done per request, or none at all when a test needs a hung write.

// File: rtl/lg_pkg.sv
`timescale 1ns/1ps
package lg_pkg;

    localparam int WORD_W  = 32;
    localparam int TICK_W  = 24;
    localparam int CAUSE_W = 8;

    localparam logic [WORD_W-CAUSE_W-1:0] SEAL_TAG = 24'h5EA1ED;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_WAIT,
        FS_DONE,
        FS_ABORT
    } flush_state_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE     = 8'd0,
        CAUSE_BROWNOUT = 8'd1,
        CAUSE_HOST     = 8'd2,
        CAUSE_PROT     = 8'd3
    } cause_e;

    typedef enum logic [1:0] {
        SLOT_ACC,
        SLOT_EVT,
        SLOT_REC,
        SLOT_SEAL
    } slot_e;

    typedef struct packed {
        cause_e              cause;
        logic [TICK_W-1:0]   tick;
    } pd_rec_t;

    function automatic cause_e pick_cause(input logic prot, input logic brown, input logic host);
        cause_e c;
        if (prot)       c = CAUSE_PROT;
        else if (brown) c = CAUSE_BROWNOUT;
        else if (host)  c = CAUSE_HOST;
        else            c = CAUSE_NONE;
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] seal_word(input logic [CAUSE_W-1:0] nwords);
        return {SEAL_TAG, nwords};
    endfunction

endpackage

// File: rtl/lg_brownout.sv
`timescale 1ns/1ps
module lg_brownout #(
    parameter int LVL_W = 12,
    parameter int DEB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  logic [LVL_W-1:0] supply_level,
    input  logic [LVL_W-1:0] threshold,
    input  logic [DEB_W-1:0] debounce,
    output logic             trip,
    output logic             pfail_flag,
    output logic             pfail_irq
);

    localparam int RW = DEB_W + 1;

    logic [DEB_W-1:0] run_q;
    logic             below;
    logic [RW-1:0]    need;
    logic [RW-1:0]    have;

    assign below = supply_level < threshold;
    assign need  = (debounce == '0) ? RW'(1) : {1'b0, debounce};
    assign have  = {1'b0, run_q} + RW'(1);
    assign trip  = sample_valid && below && (have >= need);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= '0;
            pfail_flag <= 1'b0;
            pfail_irq  <= 1'b0;
        end else begin
            pfail_irq <= trip && !pfail_flag;
            if (trip) pfail_flag <= 1'b1;
            if (sample_valid) begin
                if (!below)            run_q <= '0;
                else if (run_q != '1)  run_q <= run_q + DEB_W'(1);
            end
        end
    end

    // R1: the flag is sticky
    assert_flag_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        pfail_flag |=> pfail_flag);

    // R1: the interrupt only marks the first cycle of the flag
    assert_irq_first_R1: assert property (@(posedge clk) disable iff (rst)
        pfail_irq |-> (pfail_flag && !$past(pfail_flag)));

endmodule

// File: rtl/lg_accum.sv
`timescale 1ns/1ps
module lg_accum
    import lg_pkg::*;
#(
    parameter int INC_W = 16,
    parameter int NACC  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sample_valid,
    input  logic                         freeze,
    input  logic [NACC-1:0][INC_W-1:0]   inc,
    output logic [NACC-1:0][WORD_W-1:0]  acc
);

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)                          acc[g] <= '0;
            else if (sample_valid && !freeze) acc[g] <= acc[g] + WORD_W'(inc[g]);
        end
    end

endmodule

// File: rtl/lg_evt_ring.sv
`timescale 1ns/1ps
module lg_evt_ring #(
    parameter int DEPTH  = 4,   // power of two, at least 2
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [DATA_W-1:0]             push_data,
    input  logic [$clog2(DEPTH)-1:0]      rd_age,
    output logic [DATA_W-1:0]             rd_data,
    output logic [$clog2(DEPTH+1)-1:0]    count
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]     wptr;
    logic [PW-1:0]     rd_slot;
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                              slot_q[g] <= '0;
            else if (push && (wptr == PW'(g)))    slot_q[g] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            count <= '0;
        end else if (push) begin
            wptr <= wptr + PW'(1);
            if (count != CW'(DEPTH)) count <= count + CW'(1);
        end
    end

    assign rd_slot = wptr - PW'(1) - rd_age;
    assign rd_data = slot_q[rd_slot];

    // R4: the kept count never exceeds the depth
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

endmodule

// File: rtl/lg_flush_fsm.sv
`timescale 1ns/1ps
module lg_flush_fsm
    import lg_pkg::*;
#(
    parameter int AW    = 8,
    parameter int TMO_W = 8,
    parameter int BUD_W = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         brown_trip,
    input  logic                         prot_trip,
    input  logic                         host_off,
    input  logic [BUD_W-1:0]             cycle_budget,
    input  logic [TMO_W-1:0]             write_timeout,
    input  logic [WORD_W-1:0]            energy_snap,
    input  logic [WORD_W-1:0]            charge_snap,
    input  logic [$clog2(DEPTH+1)-1:0]   evt_count,
    input  logic [WORD_W-1:0]            evt_word,
    input  logic                         nvm_busy,
    input  logic                         nvm_done,
    output logic                         entering,
    output logic                         active,
    output logic [$clog2(DEPTH)-1:0]     evt_age,
    output logic                         nvm_wr_en,
    output logic [AW-1:0]                nvm_addr,
    output logic [WORD_W-1:0]            nvm_wdata,
    output logic                         seq_done,
    output logic                         seq_abort
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    flush_state_e      state;
    logic [AW-1:0]     widx;
    logic [CW-1:0]     n_evt;
    pd_rec_t           rec;
    logic [TICK_W-1:0] tick;
    logic [TMO_W-1:0]  tmo;
    logic [BUD_W-1:0]  bud;

    logic [AW-1:0]     total_w;
    logic [AW-1:0]     evt_end;
    logic [AW-1:0]     ev_off;
    logic              last_word;
    logic              word_ok;
    logic              tmo_hit;
    logic              bud_hit;
    slot_e             slot;

    assign entering  = (state == FS_IDLE) && (brown_trip || prot_trip || host_off);
    assign active    = (state != FS_IDLE);
    assign seq_done  = (state == FS_DONE);
    assign seq_abort = (state == FS_ABORT);

    assign total_w   = AW'(n_evt) + AW'(4);
    assign evt_end   = AW'(n_evt) + AW'(2);
    assign last_word = (widx == total_w - AW'(1));
    assign ev_off    = widx - AW'(2);
    assign evt_age   = ev_off[IW-1:0];

    assign word_ok = (state == FS_WAIT) && nvm_done;
    assign tmo_hit = ({1'b0, tmo} + (TMO_W+1)'(1)) >= {1'b0, write_timeout};
    assign bud_hit = ({1'b0, bud} + (BUD_W+1)'(1)) >= {1'b0, cycle_budget};

    always_comb begin
        if (widx < AW'(2))        slot = SLOT_ACC;
        else if (widx < evt_end)  slot = SLOT_EVT;
        else if (widx == evt_end) slot = SLOT_REC;
        else                      slot = SLOT_SEAL;
    end

    always_comb begin
        unique case (slot)
            SLOT_ACC:  nvm_wdata = (widx == '0) ? energy_snap : charge_snap;
            SLOT_EVT:  nvm_wdata = evt_word;
            SLOT_REC:  nvm_wdata = rec;
            default:   nvm_wdata = seal_word(CAUSE_W'(total_w));
        endcase
    end

    assign nvm_wr_en = (state == FS_ISSUE) && !nvm_busy;
    assign nvm_addr  = widx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            widx  <= '0;
            n_evt <= '0;
            rec   <= '{cause: CAUSE_NONE, tick: '0};
            tick  <= '0;
            tmo   <= '0;
            bud   <= '0;
        end else begin
            tick <= tick + TICK_W'(1);
            unique case (state)
                FS_IDLE: begin
                    if (entering) begin
                        state     <= FS_ISSUE;
                        widx      <= '0;
                        tmo       <= '0;
                        bud       <= '0;
                        n_evt     <= evt_count;
                        rec.cause <= pick_cause(prot_trip, brown_trip, host_off);
                        rec.tick  <= tick;
                    end
                end
                FS_ISSUE, FS_WAIT: begin
                    bud <= bud + BUD_W'(1);
                    if (word_ok && last_word) begin
                        state <= FS_DONE;
                    end else if (bud_hit || (!word_ok && tmo_hit)) begin
                        state <= FS_ABORT;
                    end else if (word_ok) begin
                        widx  <= widx + AW'(1);
                        tmo   <= '0;
                        state <= FS_ISSUE;
                    end else begin
                        tmo <= tmo + TMO_W'(1);
                        if (nvm_wr_en) state <= FS_WAIT;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // R2: the load gate holds once set
    assert_loads_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        active |=> active);

    // R6: a request is never repeated without an intervening completion
    assert_single_request_R6: assert property (@(posedge clk) disable iff (rst)
        nvm_wr_en |=> !nvm_wr_en);

    // R8: the per-word counter never passes its limit
    assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (active && !seq_done && !seq_abort && write_timeout != '0) |-> (tmo < write_timeout));

    // R9: the run counter never passes the budget
    assert_budget_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (active && !seq_done && !seq_abort && cycle_budget != '0) |-> (bud < cycle_budget));

    // R10: completion follows the storage port's done
    assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_done) |-> $past(nvm_done));

    // R10: terminal states hold
    assert_abort_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        seq_abort |=> (seq_abort && !seq_done));

endmodule

// File: rtl/lgasp_seq.sv
`timescale 1ns/1ps
module lgasp_seq
    import lg_pkg::*;
#(
    parameter int LVL_W     = 12,
    parameter int DEB_W     = 4,
    parameter int INC_W     = 16,
    parameter int EVT_DEPTH = 4,
    parameter int AW        = 8,
    parameter int TMO_W     = 8,
    parameter int BUD_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_valid,
    input  logic [LVL_W-1:0]   supply_level,
    input  logic [LVL_W-1:0]   fail_threshold,
    input  logic [DEB_W-1:0]   fail_debounce,
    input  logic [INC_W-1:0]   energy_inc,
    input  logic [INC_W-1:0]   charge_inc,
    input  logic               evt_valid,
    input  logic               evt_high_sev,
    input  logic [31:0]        evt_data,
    input  logic               prot_trip,
    input  logic               host_off,
    input  logic [BUD_W-1:0]   cycle_budget,
    input  logic [TMO_W-1:0]   write_timeout,
    input  logic               nvm_busy,
    input  logic               nvm_done,
    output logic               pfail_flag,
    output logic               pfail_irq,
    output logic               loads_off,
    output logic [31:0]        energy_acc,
    output logic [31:0]        charge_acc,
    output logic               nvm_wr_en,
    output logic [AW-1:0]      nvm_addr,
    output logic [31:0]        nvm_wdata,
    output logic               flush_done,
    output logic               flush_abort
);

    localparam int CW = $clog2(EVT_DEPTH + 1);
    localparam int IW = $clog2(EVT_DEPTH);

    logic                      brown_trip;
    logic                      entering;
    logic                      freeze;
    logic [1:0][INC_W-1:0]     inc_v;
    logic [1:0][WORD_W-1:0]    acc_v;
    logic [IW-1:0]             evt_age;
    logic [WORD_W-1:0]         evt_word;
    logic [CW-1:0]             evt_count;

    assign freeze = loads_off || entering;
    assign inc_v  = {charge_inc, energy_inc};

    lg_brownout #(.LVL_W(LVL_W), .DEB_W(DEB_W)) u_brown (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .supply_level(supply_level), .threshold(fail_threshold),
        .debounce(fail_debounce), .trip(brown_trip),
        .pfail_flag(pfail_flag), .pfail_irq(pfail_irq)
    );

    lg_accum #(.INC_W(INC_W), .NACC(2)) u_accum (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .freeze(freeze), .inc(inc_v), .acc(acc_v)
    );

    assign energy_acc = acc_v[0];
    assign charge_acc = acc_v[1];

    lg_evt_ring #(.DEPTH(EVT_DEPTH), .DATA_W(WORD_W)) u_ring (
        .clk(clk), .rst(rst),
        .push(evt_valid && evt_high_sev && !freeze),
        .push_data(evt_data), .rd_age(evt_age),
        .rd_data(evt_word), .count(evt_count)
    );

    lg_flush_fsm #(.AW(AW), .TMO_W(TMO_W), .BUD_W(BUD_W), .DEPTH(EVT_DEPTH)) u_fsm (
        .clk(clk), .rst(rst),
        .brown_trip(brown_trip), .prot_trip(prot_trip), .host_off(host_off),
        .cycle_budget(cycle_budget), .write_timeout(write_timeout),
        .energy_snap(acc_v[0]), .charge_snap(acc_v[1]),
        .evt_count(evt_count), .evt_word(evt_word),
        .nvm_busy(nvm_busy), .nvm_done(nvm_done),
        .entering(entering), .active(loads_off), .evt_age(evt_age),
        .nvm_wr_en(nvm_wr_en), .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata),
        .seq_done(flush_done), .seq_abort(flush_abort)
    );

    // R3: accumulators hold their values once loads are gated off
    assert_frozen_energy_R3: assert property (@(posedge clk) disable iff (rst)
        loads_off |=> $stable(energy_acc));
    assert_frozen_charge_R3: assert property (@(posedge clk) disable iff (rst)
        loads_off |=> $stable(charge_acc));

endmodule

// File: tb/lgasp_seq_tb_top.sv
`timescale 1ns/1ps
module lgasp_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [11:0] supply_level;
    logic [11:0] fail_threshold;
    logic [3:0]  fail_debounce;
    logic [15:0] energy_inc;
    logic [15:0] charge_inc;
    logic        evt_valid;
    logic        evt_high_sev;
    logic [31:0] evt_data;
    logic        prot_trip;
    logic        host_off;
    logic [15:0] cycle_budget;
    logic [7:0]  write_timeout;
    logic        nvm_busy;
    logic        nvm_done;
    logic        pfail_flag;
    logic        pfail_irq;
    logic        loads_off;
    logic [31:0] energy_acc;
    logic [31:0] charge_acc;
    logic        nvm_wr_en;
    logic [7:0]  nvm_addr;
    logic [31:0] nvm_wdata;
    logic        flush_done;
    logic        flush_abort;

    lgasp_seq dut_i (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .supply_level(supply_level), .fail_threshold(fail_threshold),
        .fail_debounce(fail_debounce), .energy_inc(energy_inc),
        .charge_inc(charge_inc), .evt_valid(evt_valid),
        .evt_high_sev(evt_high_sev), .evt_data(evt_data),
        .prot_trip(prot_trip), .host_off(host_off),
        .cycle_budget(cycle_budget), .write_timeout(write_timeout),
        .nvm_busy(nvm_busy), .nvm_done(nvm_done),
        .pfail_flag(pfail_flag), .pfail_irq(pfail_irq),
        .loads_off(loads_off), .energy_acc(energy_acc),
        .charge_acc(charge_acc), .nvm_wr_en(nvm_wr_en),
        .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata),
        .flush_done(flush_done), .flush_abort(flush_abort)
    );

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          overlap = 0;
    logic [31:0] mem  [256];
    int          wcnt [256];
    logic [31:0] exp_evt [8];
    int          lat = 1;
    int          hang_addr = -1;
    int          pend = 0;
    int          hang = 0;
    int          cnt = 0;
    logic [23:0] btick;
    logic [23:0] exp_tick;

    always @(posedge clk) begin
        if (rst) btick <= '0;
        else     btick <= btick + 24'd1;
    end

    // storage port model: takes a request at the negedge, answers after lat cycles
    always @(negedge clk) begin
        if (rst) begin
            nvm_busy = 1'b0;
            nvm_done = 1'b0;
            pend = 0;
            hang = 0;
        end else begin
            nvm_done = 1'b0;
            if (nvm_wr_en && nvm_busy) overlap++;
            if (pend != 0) begin
                nvm_busy = 1'b1;
                if (hang == 0) begin
                    if (cnt > 1) cnt--;
                    else begin
                        nvm_done = 1'b1;
                        nvm_busy = 1'b0;
                        pend = 0;
                    end
                end
            end else if (nvm_wr_en) begin
                mem[nvm_addr] = nvm_wdata;
                wcnt[nvm_addr]++;
                pend = 1;
                cnt = lat;
                hang = (int'(nvm_addr) == hang_addr) ? 1 : 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [15:0] bud, input logic [7:0] tmo, input int l, input int ha);
        rst = 1'b1;
        sample_valid = 0; supply_level = 12'd800; fail_threshold = 12'd100;
        fail_debounce = 4'd1; energy_inc = 0; charge_inc = 0;
        evt_valid = 0; evt_high_sev = 0; evt_data = 0;
        prot_trip = 0; host_off = 0;
        cycle_budget = bud; write_timeout = tmo;
        lat = l; hang_addr = ha; overlap = 0;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; wcnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic smp(input logic [11:0] lvl, input logic [15:0] e, input logic [15:0] c);
        @(negedge clk);
        sample_valid = 1; supply_level = lvl; energy_inc = e; charge_inc = c;
        @(negedge clk);
        sample_valid = 0;
    endtask

    task automatic push_evt(input logic sev, input logic [31:0] d);
        @(negedge clk);
        evt_valid = 1; evt_high_sev = sev; evt_data = d;
        @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic pulse_trig(input logic p, input logic h);
        @(negedge clk);
        prot_trip = p; host_off = h;
        @(negedge clk);
        prot_trip = 0; host_off = 0;
        exp_tick = btick - 24'd1;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 3000; i++) begin
            if (flush_done || flush_abort) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_page(input int n, input logic [7:0] cause, input logic [31:0] e, input logic [31:0] c);
        chk("R5", "energy word", mem[0], e);
        chk("R5", "charge word", mem[1], c);
        for (int k = 0; k < n; k++) chk("R4", "event word", mem[2+k], exp_evt[k]);
        chk("R7", "power-down record", mem[2+n], {cause, exp_tick});
        chk("R5", "seal word", mem[3+n], {24'h5EA1ED, 8'(n + 4)});
        for (int a = 0; a < n + 4; a++) chk("R6", "writes per address", 32'(wcnt[a]), 32'd1);
        chk("R5", "nothing past seal", 32'(wcnt[n+4]), 32'd0);
        chk("R6", "request while busy", 32'(overlap), 32'd0);
        chk("R10", "done/abort", {30'd0, flush_done, flush_abort}, 32'd2);
    endtask

    task automatic t_reset();
        apply_reset(16'd1000, 8'd8, 1, -1);
        @(negedge clk);
        chk("R11", "flag/irq/gate", {29'd0, pfail_flag, pfail_irq, loads_off}, 32'd0);
        chk("R11", "write/done/abort", {29'd0, nvm_wr_en, flush_done, flush_abort}, 32'd0);
        chk("R11", "energy", energy_acc, 32'd0);
        chk("R11", "charge", charge_acc, 32'd0);
    endtask

    task automatic t_debounce();
        apply_reset(16'd1000, 8'd8, 1, -1);
        fail_debounce = 4'd3;
        smp(12'd50, 0, 0); smp(12'd50, 0, 0);
        chk("R1", "flag after two low", {31'd0, pfail_flag}, 32'd0);
        smp(12'd100, 0, 0);
        chk("R1", "flag after at-threshold", {31'd0, pfail_flag}, 32'd0);
        smp(12'd50, 0, 0); smp(12'd50, 0, 0);
        repeat (3) @(negedge clk);
        chk("R1", "gaps neither count nor reset", {31'd0, pfail_flag}, 32'd0);
        smp(12'd50, 0, 0);
        chk("R1", "flag on third low", {31'd0, pfail_flag}, 32'd1);
        chk("R1", "irq pulse", {31'd0, pfail_irq}, 32'd1);
        chk("R2", "loads gated", {31'd0, loads_off}, 32'd1);
        @(negedge clk);
        chk("R1", "irq one cycle", {31'd0, pfail_irq}, 32'd0);
        chk("R1", "flag sticky", {31'd0, pfail_flag}, 32'd1);
        wait_end();
        chk("R2", "brown-out cause", mem[2][31:24], 32'd1);
    endtask

    task automatic t_main_flush();
        apply_reset(16'd1000, 8'd8, 2, -1);
        for (int i = 0; i < 4; i++) smp(12'd500, 16'd10, 16'd3);
        push_evt(1, 32'hA000_0001);
        push_evt(0, 32'hB000_0001);
        push_evt(1, 32'hA000_0002);
        push_evt(1, 32'hA000_0003);
        smp(12'd500, 16'd7, 16'd1);
        chk("R3", "energy before trip", energy_acc, 32'd47);
        smp(12'd20, 16'd100, 16'd100);
        exp_tick = btick - 24'd1;
        chk("R2", "loads gated", {31'd0, loads_off}, 32'd1);
        chk("R3", "trip sample not added", energy_acc, 32'd47);
        smp(12'd20, 16'd5, 16'd5);
        push_evt(1, 32'hA000_0009);
        smp(12'd900, 16'd5, 16'd5);
        chk("R3", "energy frozen", energy_acc, 32'd47);
        chk("R3", "charge frozen", charge_acc, 32'd13);
        exp_evt[0] = 32'hA000_0003; exp_evt[1] = 32'hA000_0002; exp_evt[2] = 32'hA000_0001;
        wait_end();
        check_page(3, 8'd1, 32'd47, 32'd13);
    endtask

    task automatic t_ring_host();
        apply_reset(16'd1000, 8'd8, 1, -1);
        for (int i = 1; i <= 6; i++) push_evt(1, 32'hD000_0000 + 32'(i));
        push_evt(0, 32'hBBBB_0000);
        pulse_trig(0, 1);
        chk("R2", "host no pfail flag", {31'd0, pfail_flag}, 32'd0);
        for (int k = 0; k < 4; k++) exp_evt[k] = 32'hD000_0006 - 32'(k);
        wait_end();
        check_page(4, 8'd2, 32'd0, 32'd0);
    endtask

    task automatic t_priority();
        apply_reset(16'd1000, 8'd8, 1, -1);
        pulse_trig(1, 1);
        wait_end();
        check_page(0, 8'd3, 32'd0, 32'd0);
    endtask

    task automatic t_timeout();
        apply_reset(16'd1000, 8'd6, 1, 3);
        push_evt(1, 32'hC000_0001);
        push_evt(1, 32'hC000_0002);
        pulse_trig(0, 1);
        wait_end();
        chk("R8", "abort/done", {30'd0, flush_done, flush_abort}, 32'd1);
        chk("R8", "hung word issued", 32'(wcnt[3]), 32'd1);
        chk("R8", "no record", 32'(wcnt[4]), 32'd0);
        chk("R8", "no seal", 32'(wcnt[5]), 32'd0);
        chk("R10", "abort sticky", {31'd0, flush_abort}, 32'd1);
    endtask

    task automatic t_budget();
        apply_reset(16'd10, 8'd8, 3, -1);
        pulse_trig(0, 1);
        wait_end();
        chk("R9", "abort/done", {30'd0, flush_done, flush_abort}, 32'd1);
        chk("R9", "third word issued", 32'(wcnt[2]), 32'd1);
        chk("R9", "no seal", 32'(wcnt[3]), 32'd0);
    endtask

    task automatic t_latency();
        apply_reset(16'd1000, 8'd8, 5, -1);
        pulse_trig(0, 1);
        wait_end();
        check_page(0, 8'd2, 32'd0, 32'd0);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_debounce();
        t_main_flush();
        t_ring_host();
        t_priority();
        t_timeout();
        t_budget();
        t_latency();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule